// File: doc/BRIEF.md
# Multi-Scatterer Baseband Echo Generator

This block builds a synthetic target echo from a complex baseband reference stream, which is the intercepted IF pulse after down-conversion. Every incoming sample goes into a circular history buffer. Each of `NUM_SCAT` scattering points reads its own delayed copy from that buffer. The copy is turned by a per-point Doppler rotation, drawn from a phase accumulator and a cosine table, and then weighted by a per-point amplitude. All weighted copies are added into one complex output sample. One point with a nonzero weight forms a point target. Several points with different delays and relative rotations form an extended target.

Delay, Doppler step and weight are computed elsewhere (from target kinematics and the measured carrier) and written through a small register port. Writes land in a shadow copy. A gate strobe, which marks the range-gate reference, moves the shadow copy into use and restarts every phase accumulator. The output stays at baseband and is meant for later up-conversion and playback.

Top module: `echo_gen`

## Requirements
- R1: `out_valid` is high exactly three clock cycles after each cycle with `in_valid` high, and is low at all other times.
- R2: For the sample numbered n, scatterer k uses the reference sample numbered n − ((gate offset + delay_k) mod 1024). A total of 0 selects the current sample, and totals of 1024 or more wrap around the 1024-entry history.
- R3: Each scatterer keeps a 32-bit phase that grows by its signed step on every accepted sample. Bits 31:22 of the phase before the step form the index p. The table holds T[j] = round(32767·cos(2πj/1024)), c = T[p] and s = T[(p − 256) mod 1024]. The rotated sample is ri = (xi·c − xq·s) >>> 15 and rq = (xi·s + xq·c) >>> 15, where >>> is an arithmetic shift (floor).
- R4: The weight is an unsigned 16-bit value with 15 fraction bits (0x8000 = 1.0). Each rotated component is scaled as (r·g) >>> 15.
- R5: The scaled components of all scatterers are summed per rail. Each sum is clamped to the range −32768 to 32767.
- R6: When `cfg_we` is high, `cfg_data` is written into the shadow settings. `cfg_field` selects the target: 0 is the delay of scatterer `cfg_sel` (bits 9:0), 1 is its phase step (bits 31:0), 2 is its weight (bits 15:0), and 3 is the global gate offset (bits 9:0, `cfg_sel` ignored). A shadow write has no effect on the output until a gate strobe.
- R7: On a cycle with `gate_strobe` high, the shadow settings become active and every phase accumulator restarts at zero. A sample accepted in that same cycle already uses the new settings and phase 0.
- R8: After reset, `out_valid`, `out_i` and `out_q` are zero, and all settings and phases are zero, so every output is 0 until a weight is loaded and gated.
- R9: Cycles without `in_valid` do not advance any phase accumulator or the history position.
- R10: `out_i` and `out_q` keep their last value while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Reference sample present this cycle |
| in_i | input | 16 | Reference in-phase, two's complement |
| in_q | input | 16 | Reference quadrature, two's complement |
| gate_strobe | input | 1 | Range-gate reference; activates shadow settings |
| cfg_we | input | 1 | Shadow setting write enable |
| cfg_sel | input | SEL_W (2) | Scatterer index for the write |
| cfg_field | input | 2 | Setting selector (see R6) |
| cfg_data | input | 32 | Setting value |
| out_valid | output | 1 | Echo sample present |
| out_i | output | 16 | Echo in-phase, saturated |
| out_q | output | 16 | Echo quadrature, saturated |

## Verification
The first pattern is a single unit-weight scatterer with zero delay and zero step. It exposes the truncation of the rotation and of the weighting on its own. Next comes a ramp with three scatterers at different delays, with opposite quarter-turn Doppler steps and with idle gaps between samples. It separates delay mistakes from rotation-sign mistakes, and it shows whether the phase advances on cycles without a sample. A delay past the buffer end checks the address wrap. Full-scale samples of both signs on three scatterers at maximum weight drive both rails into clamping. A small sample afterwards confirms that the clamp lets in-range sums through. The remaining patterns are a single isolated sample, which measures the latency, and shadow writes with no strobe, which must leave the output unchanged.

// File: rtl/echo_gen_pkg.sv
package echo_gen_pkg;
    localparam int SAMP_W  = 16;
    localparam int PHASE_W = 32;
    localparam int LUT_W   = 10;
    localparam int ADDR_W  = 10;
    localparam int GAIN_W  = 16;
    localparam int ROT_W   = SAMP_W + 2;

    typedef enum logic [1:0] {
        FLD_DELAY   = 2'd0,
        FLD_STEP    = 2'd1,
        FLD_GAIN    = 2'd2,
        FLD_GATEOFF = 2'd3
    } cfg_field_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  delay;
        logic [PHASE_W-1:0] step;
        logic [GAIN_W-1:0]  gain;
    } scat_cfg_t;

    // Rounded full-scale cosine for table entry k of a 2**lut_w table.
    function automatic logic [SAMP_W-1:0] cos_code(input int k, input int lut_w);
        real ang;
        real r;
        int  v;
        ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(1 << lut_w);
        r   = real'((1 << (SAMP_W - 1)) - 1) * $cos(ang);
        if (r >= 0.0) v = $rtoi(r + 0.5);
        else          v = -$rtoi(0.5 - r);
        return SAMP_W'(v);
    endfunction
endpackage

// File: rtl/echo_quad_rom.sv
module echo_quad_rom
    import echo_gen_pkg::*;
#(
    parameter int TBL_W  = LUT_W,
    parameter int NUM_RD = 1
) (
    input  logic [NUM_RD-1:0][TBL_W-1:0]  idx,
    output logic [NUM_RD-1:0][SAMP_W-1:0] cos_o,
    output logic [NUM_RD-1:0][SAMP_W-1:0] sin_o
);
    localparam int ENTRIES = 1 << TBL_W;
    localparam logic [TBL_W-1:0] QUARTER = TBL_W'(ENTRIES / 4);

    logic [SAMP_W-1:0] tbl [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_tbl
        localparam logic [SAMP_W-1:0] VAL = cos_code(k, TBL_W);
        assign tbl[k] = VAL;
    end

    // sine is the cosine a quarter turn earlier
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign cos_o[r] = tbl[idx[r]];
        assign sin_o[r] = tbl[idx[r] - QUARTER];
    end
endmodule

// File: rtl/echo_delay_ram.sv
module echo_delay_ram #(
    parameter int AW     = 10,
    parameter int WORD_W = 32,
    parameter int NUM_RD = 1
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  wr_addr,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [NUM_RD-1:0][AW-1:0]      rd_addr,
    output logic [NUM_RD-1:0][WORD_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rd_data[r] = mem[rd_addr[r]];
    end
endmodule

// File: rtl/echo_rotator.sv
module echo_rotator #(
    parameter int IN_W  = 16,
    parameter int OUT_W = IN_W + 2
) (
    input  logic signed [IN_W-1:0]  x_i,
    input  logic signed [IN_W-1:0]  x_q,
    input  logic signed [IN_W-1:0]  c,
    input  logic signed [IN_W-1:0]  s,
    output logic signed [OUT_W-1:0] y_i,
    output logic signed [OUT_W-1:0] y_q
);
    localparam int PROD_W = 2 * IN_W + 1;

    logic signed [PROD_W-1:0] p_i;
    logic signed [PROD_W-1:0] p_q;

    always_comb begin
        p_i = PROD_W'(x_i) * PROD_W'(c) - PROD_W'(x_q) * PROD_W'(s);
        p_q = PROD_W'(x_i) * PROD_W'(s) + PROD_W'(x_q) * PROD_W'(c);
        y_i = OUT_W'(p_i >>> (IN_W - 1));
        y_q = OUT_W'(p_q >>> (IN_W - 1));
    end
endmodule

// File: rtl/echo_gen.sv
module echo_gen
    import echo_gen_pkg::*;
#(
    parameter int NUM_SCAT = 3,
    parameter int SEL_W    = (NUM_SCAT > 1) ? $clog2(NUM_SCAT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_i,
    input  logic [SAMP_W-1:0] in_q,
    input  logic              gate_strobe,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [1:0]        cfg_field,
    input  logic [31:0]       cfg_data,
    output logic              out_valid,
    output logic [SAMP_W-1:0] out_i,
    output logic [SAMP_W-1:0] out_q
);
    localparam int SCL_W   = ROT_W + 2;
    localparam int PRODG_W = ROT_W + GAIN_W + 1;
    localparam int SUM_W   = SCL_W + $clog2(NUM_SCAT + 1);
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (SAMP_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SUM_W'(1 << (SAMP_W - 1));

    typedef struct packed {
        logic [ADDR_W-1:0]                  wp;
        logic [NUM_SCAT-1:0][PHASE_W-1:0]   acc;
        scat_cfg_t [NUM_SCAT-1:0]           act;
        scat_cfg_t [NUM_SCAT-1:0]           shd;
        logic [ADDR_W-1:0]                  goff_act;
        logic [ADDR_W-1:0]                  goff_shd;
        logic                               v1;
        logic [NUM_SCAT-1:0][ADDR_W-1:0]    addr1;
        logic [NUM_SCAT-1:0][LUT_W-1:0]     ph1;
        logic [NUM_SCAT-1:0][GAIN_W-1:0]    gain1;
        logic                               v2;
        logic [NUM_SCAT-1:0][ROT_W-1:0]     rot_i2;
        logic [NUM_SCAT-1:0][ROT_W-1:0]     rot_q2;
        logic [NUM_SCAT-1:0][GAIN_W-1:0]    gain2;
        logic                               vo;
        logic [SAMP_W-1:0]                  oi;
        logic [SAMP_W-1:0]                  oq;
    } state_t;

    state_t st_d, st_q;

    scat_cfg_t [NUM_SCAT-1:0]            eff;
    logic [ADDR_W-1:0]                   goff_eff;
    logic [PHASE_W-1:0]                  base;
    logic signed [SUM_W-1:0]             sum_i, sum_q;
    logic [NUM_SCAT-1:0][2*SAMP_W-1:0]   rd_word;
    logic [NUM_SCAT-1:0][SAMP_W-1:0]     cos_w, sin_w;
    logic [NUM_SCAT-1:0][ROT_W-1:0]      rot_i_w, rot_q_w;

    function automatic logic signed [SCL_W-1:0] scale(input logic [ROT_W-1:0] r,
                                                      input logic [GAIN_W-1:0] g);
        logic signed [PRODG_W-1:0] p;
        p = PRODG_W'($signed(r)) * PRODG_W'($signed({1'b0, g}));
        return SCL_W'(p >>> (GAIN_W - 1));
    endfunction

    function automatic logic [SAMP_W-1:0] clip(input logic signed [SUM_W-1:0] v);
        if (v > SAT_HI)      return SAT_HI[SAMP_W-1:0];
        else if (v < SAT_LO) return SAT_LO[SAMP_W-1:0];
        else                 return v[SAMP_W-1:0];
    endfunction

    echo_delay_ram #(.AW(ADDR_W), .WORD_W(2 * SAMP_W), .NUM_RD(NUM_SCAT)) u_hist (
        .clk     (clk),
        .wr_en   (in_valid),
        .wr_addr (st_q.wp),
        .wr_data ({in_i, in_q}),
        .rd_addr (st_q.addr1),
        .rd_data (rd_word)
    );

    echo_quad_rom #(.TBL_W(LUT_W), .NUM_RD(NUM_SCAT)) u_rom (
        .idx   (st_q.ph1),
        .cos_o (cos_w),
        .sin_o (sin_w)
    );

    for (genvar k = 0; k < NUM_SCAT; k++) begin : g_lane
        echo_rotator #(.IN_W(SAMP_W), .OUT_W(ROT_W)) u_rot (
            .x_i (rd_word[k][2*SAMP_W-1:SAMP_W]),
            .x_q (rd_word[k][SAMP_W-1:0]),
            .c   (cos_w[k]),
            .s   (sin_w[k]),
            .y_i (rot_i_w[k]),
            .y_q (rot_q_w[k])
        );
    end

    always_comb begin
        st_d  = st_q;
        sum_i = '0;
        sum_q = '0;
        base  = '0;

        // shadow writes
        if (cfg_we) begin
            case (cfg_field_e'(cfg_field))
                FLD_DELAY:   if (int'(cfg_sel) < NUM_SCAT) st_d.shd[cfg_sel].delay = cfg_data[ADDR_W-1:0];
                FLD_STEP:    if (int'(cfg_sel) < NUM_SCAT) st_d.shd[cfg_sel].step  = cfg_data;
                FLD_GAIN:    if (int'(cfg_sel) < NUM_SCAT) st_d.shd[cfg_sel].gain  = cfg_data[GAIN_W-1:0];
                FLD_GATEOFF: st_d.goff_shd = cfg_data[ADDR_W-1:0];
            endcase
        end

        // gate reference: swap in shadow settings
        eff      = gate_strobe ? st_q.shd      : st_q.act;
        goff_eff = gate_strobe ? st_q.goff_shd : st_q.goff_act;
        if (gate_strobe) begin
            st_d.act      = st_q.shd;
            st_d.goff_act = st_q.goff_shd;
        end

        // stage 1: addresses, phase index, weight
        st_d.v1 = in_valid;
        for (int k = 0; k < NUM_SCAT; k++) begin
            base = gate_strobe ? '0 : st_q.acc[k];
            st_d.acc[k] = in_valid ? base + eff[k].step : base;
            if (in_valid) begin
                st_d.ph1[k]   = base[PHASE_W-1 -: LUT_W];
                st_d.addr1[k] = st_q.wp - goff_eff - eff[k].delay;
                st_d.gain1[k] = eff[k].gain;
            end
        end
        if (in_valid) st_d.wp = st_q.wp + ADDR_W'(1);

        // stage 2: rotated copies
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.rot_i2 = rot_i_w;
            st_d.rot_q2 = rot_q_w;
            st_d.gain2  = st_q.gain1;
        end

        // stage 3: weight, sum, clamp
        st_d.vo = st_q.v2;
        if (st_q.v2) begin
            for (int k = 0; k < NUM_SCAT; k++) begin
                sum_i = sum_i + SUM_W'(scale(st_q.rot_i2[k], st_q.gain2[k]));
                sum_q = sum_q + SUM_W'(scale(st_q.rot_q2[k], st_q.gain2[k]));
            end
            st_d.oi = clip(sum_i);
            st_d.oq = clip(sum_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vo;
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;
endmodule

// File: rtl/echo_gen_chk.sv
module echo_gen_chk
    import echo_gen_pkg::*;
#(
    parameter int NUM_SCAT = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              in_valid,
    input logic                              gate_strobe,
    input logic                              out_valid,
    input logic [SAMP_W-1:0]                 out_i,
    input logic [SAMP_W-1:0]                 out_q,
    input logic [NUM_SCAT*PHASE_W-1:0]       acc_flat,
    input logic [NUM_SCAT*$bits(scat_cfg_t)-1:0] act_flat
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_settings_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_strobe |=> $stable(act_flat));

    assert_phase_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_strobe && !in_valid) |=> (acc_flat == '0));

    assert_idle_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !gate_strobe) |=> $stable(acc_flat));

    assert_output_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && !out_valid) |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind echo_gen echo_gen_chk #(.NUM_SCAT(NUM_SCAT)) u_echo_gen_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .gate_strobe (gate_strobe),
    .out_valid   (out_valid),
    .out_i       (out_i),
    .out_q       (out_q),
    .acc_flat    (st_q.acc),
    .act_flat    (st_q.act)
);

// File: tb/echo_gen_bench.sv
module echo_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 3;
    localparam int HIST = 4096;

    typedef struct {
        int    ei;
        int    eq;
        bit    dc;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0, in_q = '0;
    logic        gate_strobe = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_data = '0;
    logic        out_valid;
    logic [15:0] out_i, out_q;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;

    int        hist_i [HIST];
    int        hist_q [HIST];
    int        n_samp = 0;
    int        sh_delay [NS], ac_delay [NS];
    bit [31:0] sh_step [NS], ac_step [NS];
    int        sh_gain [NS], ac_gain [NS];
    int        sh_goff = 0, ac_goff = 0;
    bit [31:0] m_acc [NS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    echo_gen #(.NUM_SCAT(NS)) u_echo_gen (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_i (in_i), .in_q (in_q),
        .gate_strobe (gate_strobe), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
        .cfg_field (cfg_field), .cfg_data (cfg_data),
        .out_valid (out_valid), .out_i (out_i), .out_q (out_q)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void quad(input int idx, output longint c, output longint s);
        case (idx)
            0:       begin c = 32767;  s = 0;      end
            256:     begin c = 0;      s = 32767;  end
            512:     begin c = -32767; s = 0;      end
            default: begin c = 0;      s = -32767; end
        endcase
    endfunction

    function automatic int clamp(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic void apply_gate();
        for (int k = 0; k < NS; k++) begin
            ac_delay[k] = sh_delay[k];
            ac_step[k]  = sh_step[k];
            ac_gain[k]  = sh_gain[k];
            m_acc[k]    = '0;
        end
        ac_goff = sh_goff;
    endfunction

    task automatic cfg_write(input int sel, input int fld, input bit [31:0] data);
        @(negedge clk);
        in_valid = 1'b0; gate_strobe = 1'b0;
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_field = 2'(fld); cfg_data = data;
        case (fld)
            0: sh_delay[sel] = int'(data & 32'h3FF);
            1: sh_step[sel]  = data;
            2: sh_gain[sel]  = int'(data & 32'hFFFF);
            default: sh_goff = int'(data & 32'h3FF);
        endcase
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; gate_strobe = 1'b0; cfg_we = 1'b0;
        end
    endtask

    task automatic gate_only();
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0; gate_strobe = 1'b1;
        apply_gate();
    endtask

    // driver: one sample in, one expected item pushed
    task automatic send(input int xi, input int xq, input bit g, input bit dc_in, input string tag);
        exp_t   e;
        longint si, sq;
        si = 0; sq = 0;
        e.dc = dc_in;
        @(negedge clk);
        in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq); gate_strobe = g; cfg_we = 1'b0;
        if (g) apply_gate();
        hist_i[n_samp] = xi;
        hist_q[n_samp] = xq;
        for (int k = 0; k < NS; k++) begin
            int     tot, src, idx;
            longint c, s, ri, rq;
            tot = (ac_goff + ac_delay[k]) % 1024;
            src = n_samp - tot;
            idx = int'(m_acc[k][31:22]);
            if (ac_gain[k] != 0) begin
                if (src < 0 || (idx % 256) != 0) e.dc = 1'b1;
                else begin
                    quad(idx, c, s);
                    ri = (longint'(hist_i[src]) * c - longint'(hist_q[src]) * s) >>> 15;
                    rq = (longint'(hist_i[src]) * s + longint'(hist_q[src]) * c) >>> 15;
                    si += (ri * longint'(ac_gain[k])) >>> 15;
                    sq += (rq * longint'(ac_gain[k])) >>> 15;
                end
            end
            m_acc[k] = m_acc[k] + ac_step[k];
        end
        e.ei  = clamp(si);
        e.eq  = clamp(sq);
        e.tag = tag;
        sb.push_back(e);
        n_samp++;
    endtask

    // monitor: pop and compare as outputs appear
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R1: actual=out_valid 1 expected=no output pending");
            end else begin
                e = sb.pop_front();
                if (!e.dc) begin
                    check(int'($signed(out_i)) == e.ei, {e.tag, " out_i"}, int'($signed(out_i)), e.ei);
                    check(int'($signed(out_q)) == e.eq, {e.tag, " out_q"}, int'($signed(out_q)), e.eq);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] held_i, held_q;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        check(out_i == '0 && out_q == '0, "R8 outputs in reset", int'(out_i), 0);
        rst_n = 1'b1;

        send(100, 50, 1'b0, 1'b0, "R8 zero weights after reset");
        for (int n = 0; n < 1030; n++) send(0, 0, 1'b0, 1'b1, "prime");

        // unit weight, no delay, no Doppler
        cfg_write(0, 0, 32'd0);
        cfg_write(0, 1, 32'd0);
        cfg_write(0, 2, 32'h8000);
        cfg_write(0, 3, 32'd0);
        send(1000, -500, 1'b0, 1'b0, "R6 shadow write before gate");
        send(1000, -500, 1'b1, 1'b0, "R7 gate with sample");
        send(-1234, 777, 1'b0, 1'b0, "R4 unit weight");

        // three scatterers, opposite quarter-turn steps, idle gaps
        cfg_write(0, 0, 32'd1);
        cfg_write(0, 2, 32'h2000);
        cfg_write(1, 0, 32'd3);
        cfg_write(1, 1, 32'h4000_0000);
        cfg_write(1, 2, 32'h4000);
        cfg_write(2, 0, 32'd5);
        cfg_write(2, 1, 32'hC000_0000);
        cfg_write(2, 2, 32'hC000);
        cfg_write(0, 3, 32'd2);
        gate_only();
        for (int n = 0; n < 12; n++) begin
            send(n * 300 - 1500, 2000 - n * 170, 1'b0, 1'b0, "R2 R3 R4 R9 multi-scatterer");
            if (n % 3 == 2) idle(2);
        end

        // delay past the end of the history wraps
        cfg_write(0, 0, 32'd1023);
        cfg_write(1, 2, 32'd0);
        cfg_write(2, 2, 32'd0);
        send(4321, -222, 1'b1, 1'b0, "R2 wrapped delay");
        for (int n = 0; n < 4; n++) send(700 * n - 900, 333 - 50 * n, 1'b0, 1'b0, "R2 wrapped delay");

        // clamping on both rails
        for (int k = 0; k < NS; k++) begin
            cfg_write(k, 0, 32'd0);
            cfg_write(k, 1, 32'd0);
            cfg_write(k, 2, 32'hFFFF);
        end
        cfg_write(0, 3, 32'd0);
        send(30000, -30000, 1'b1, 1'b0, "R5 clamp");
        send(-30000, 30000, 1'b0, 1'b0, "R5 clamp");
        send(100, -100, 1'b0, 1'b0, "R5 in-range sum");

        // isolated sample latency
        idle(6);
        send(10, 20, 1'b0, 1'b0, "R1 isolated sample");
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R1 one cycle after", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 two cycles after", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1 three cycles after", int'(out_valid), 1);

        // outputs hold while idle
        idle(2);
        held_i = out_i; held_q = out_q;
        idle(5);
        check(out_i == held_i && out_q == held_q && !out_valid, "R10 hold while idle",
              int'($signed(out_i)), int'($signed(held_i)));

        check(sb.size() == 0, "R1 all outputs delivered", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule